// File: doc/BRIEF.md
# Masked-CRC Wakeup Frame Matcher

This block watches a received frame one byte per cycle and decides whether it matches any of eight programmed wakeup samples. Each sample is described by a byte-select mask, a reference CRC computed over the selected bytes only, and a reference copy of the last selected byte. Every sample has its own CRC accumulator. All accumulators run side by side as bytes arrive, so the verdict is ready shortly after the last byte.

A long mode joins slots 2 and 3, 4 and 5, and 6 and 7 into three wide samples. Each joined pair has a 128-byte window starting at offset 0 and a 16-bit CRC. Slots 0 and 1 keep their normal behaviour, so five samples are live in this mode. A wake is reported only if the frame passed its own FCS check, its destination address was accepted, and power-management wake is enabled. The block then emits a one-cycle pulse together with the index of the lowest matching slot.

Top module: `wkf_matcher`

## Requirements
- R1: After reset `wake` is 0 and `wake_slot` is 0.
- R2: In normal mode, mask bit k of a slot (slot s uses `slot_mask[s*64+k]`) selects frame byte offset 12+k. Bytes at offsets below 12 or above 75, and unselected bytes inside the window, do not affect the result.
- R3: The normal CRC is x^8+x^2+x+1 (0x07), seeded 0xFF, and is fed MSB-first with each selected byte in offset order.
- R4: A normal slot matches only if its CRC equals `slot_crc_lo[s*8+:8]` and the last selected byte equals `slot_crc_hi[s*8+:8]`.
- R5: A slot whose mask selects no byte in the frame never matches.
- R6: A wake needs `rx_addr_hit`, `rx_crc_ok` and `pme_en` all high. All three are sampled with the end-of-frame byte.
- R7: With `long_mode` high, each pair (e, e+1) for e in {2,4,6} forms one 128-bit mask. Bit j, for j in 0..63, comes from slot e's mask bit j, and bit 64+j comes from slot e+1's mask bit j. Mask bit j selects byte offset j. The CRC is x^16+x^15+x^2+1 (0x8005), seeded 0xFFFF and fed MSB-first, and must equal {`slot_crc_hi` of e, `slot_crc_lo` of e}. No last-byte compare is made.
- R8: With `long_mode` high, odd slots 3, 5 and 7 are never reported, and slots 0 and 1 still match as in normal mode. The value of `long_mode` held with the end-of-frame byte applies.
- R9: The end-of-frame byte is the byte with `rx_vld` and `rx_eof` both high. `wake` is high for exactly the single cycle after the second rising edge that follows it. `wake_slot` then gives the lowest-numbered matching slot.
- R10: A byte at offset 0 restarts every accumulator, so an earlier frame never affects the verdict on a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Received byte valid |
| rx_dat | input | 8 | Received byte |
| rx_off | input | OFFS_W | Byte offset within the frame |
| rx_eof | input | 1 | Marks the last byte of the frame |
| rx_crc_ok | input | 1 | Frame FCS is good |
| rx_addr_hit | input | 1 | Destination address accepted |
| pme_en | input | 1 | Power-management wake enabled |
| long_mode | input | 1 | Join slot pairs into long samples |
| slot_mask | input | 8*64 | Per-slot byte mask, 64 bits per slot |
| slot_crc_lo | input | 8*8 | Per-slot CRC (low byte in long mode) |
| slot_crc_hi | input | 8*8 | Per-slot last selected byte, or CRC high byte of a long slot |
| wake | output | 1 | One-cycle wake pulse |
| wake_slot | output | 3 | Index of the matching slot |

## Verification
The bench exercises the window edges at offsets 12 and 75, and the bytes just outside them. A design with an off-by-one window would wake on a changed byte at offset 11 or 76, or miss a change at 12 or 75. It programs an all-zero mask whose references equal the CRC seed and a zero last byte. A design that lacks the "at least one byte selected" rule would wake on every frame. In long mode it checks that the odd partner of a pair is never reported, that slots 0 and 1 still match, and that the high CRC byte replaces the last-byte compare. It also checks priority among several matching slots, the exact cycle and width of the pulse, each qualifier separately, and that one frame does not carry into the next.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

    localparam int SLOT_CNT   = 8;
    localparam int SLOT_W     = $clog2(SLOT_CNT);
    localparam int FIRST_LONG = 2;
    localparam int LONG_CNT   = (SLOT_CNT - FIRST_LONG) / 2;
    localparam int NORM_LO    = 12;
    localparam int NORM_LEN   = 64;
    localparam int LONG_LEN   = 2 * NORM_LEN;
    localparam int CRC_MAX_W  = 16;

    // Polynomials left-aligned in a 16-bit register
    localparam logic [CRC_MAX_W-1:0] POLY_SHORT = 16'h0700;
    localparam logic [CRC_MAX_W-1:0] POLY_LONG  = 16'h8005;

    typedef struct packed {
        logic [CRC_MAX_W-1:0] crc;
        logic [7:0]           last;
        logic                 seen;
    } lane_state_t;

    typedef struct packed {
        logic              pend;
        logic              qual;
        logic              lmode;
        logic              wake;
        logic [SLOT_W-1:0] slot;
    } dec_state_t;

    // One byte, MSB first, on a left-aligned CRC register
    function automatic logic [CRC_MAX_W-1:0] crc_byte(
        input logic [CRC_MAX_W-1:0] c,
        input logic [7:0]           b,
        input logic [CRC_MAX_W-1:0] poly
    );
        logic [CRC_MAX_W-1:0] r;
        r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[CRC_MAX_W-1] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/wkf_lane.sv
module wkf_lane
    import wkf_pkg::*;
#(
    parameter int              OFFS_W   = 11,
    parameter int              WIN_LO   = 12,
    parameter int              WIN_LEN  = 64,
    parameter int              CRC_W    = 8,
    parameter logic [15:0]     POLY     = 16'h0700,
    parameter bit              USE_LAST = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_vld,
    input  logic [7:0]         byte_dat,
    input  logic [OFFS_W-1:0]  byte_off,
    input  logic [WIN_LEN-1:0] lane_mask,
    input  logic [CRC_W-1:0]   ref_crc,
    input  logic [7:0]         ref_last,
    output logic               hit
);

    localparam int                   IDX_W = $clog2(WIN_LEN);
    localparam logic [OFFS_W-1:0]    LO_O  = OFFS_W'(WIN_LO);
    localparam logic [OFFS_W-1:0]    LEN_O = OFFS_W'(WIN_LEN);
    localparam logic [CRC_MAX_W-1:0] SEED  = 16'hFFFF << (CRC_MAX_W - CRC_W);
    localparam lane_state_t          FRESH = '{crc: SEED, last: 8'h00, seen: 1'b0};

    lane_state_t       st_d, st_q;
    logic [OFFS_W-1:0] rel;
    logic              in_win;
    logic              take;
    logic              last_ok;

    // Offsets below the window wrap to large values and fall out
    assign rel    = byte_off - LO_O;
    assign in_win = rel < LEN_O;
    assign take   = byte_vld && in_win && lane_mask[rel[IDX_W-1:0]];

    always_comb begin
        st_d = st_q;
        if (byte_vld && byte_off == '0) begin
            st_d = FRESH;
        end
        if (take) begin
            st_d.crc  = crc_byte(st_d.crc, byte_dat, POLY);
            st_d.last = byte_dat;
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FRESH;
        else        st_q <= st_d;
    end

    assign last_ok = USE_LAST ? (st_q.last == ref_last) : 1'b1;
    assign hit     = st_q.seen && (st_q.crc[CRC_MAX_W-1 -: CRC_W] == ref_crc) && last_ok;

    // R2: a byte outside the window leaves the running CRC untouched
    p_outside_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_off != '0 && !in_win) |=> $stable(st_q.crc));

    // R10: an unselected byte at offset 0 leaves the lane empty
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_off == '0 && !take) |=> (!st_q.seen && !hit));

endmodule

// File: rtl/wkf_decide.sv
module wkf_decide
    import wkf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_end,
    input  logic                addr_hit,
    input  logic                fcs_ok,
    input  logic                pme_en,
    input  logic                long_mode,
    input  logic [SLOT_CNT-1:0] norm_hit,
    input  logic [LONG_CNT-1:0] long_hit,
    output logic                wake,
    output logic [SLOT_W-1:0]   wake_slot
);

    dec_state_t          st_d, st_q;
    logic [SLOT_CNT-1:0] eff;
    logic [SLOT_W-1:0]   sel;

    // Pick the per-slot verdict according to the latched mode
    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_eff
        if (s >= FIRST_LONG && ((s - FIRST_LONG) % 2) == 0) begin : g_even
            assign eff[s] = st_q.lmode ? long_hit[(s - FIRST_LONG) / 2] : norm_hit[s];
        end else if (s >= FIRST_LONG) begin : g_odd
            assign eff[s] = st_q.lmode ? 1'b0 : norm_hit[s];
        end else begin : g_base
            assign eff[s] = norm_hit[s];
        end
    end

    always_comb begin
        sel = '0;
        for (int s = SLOT_CNT - 1; s >= 0; s--) begin
            if (eff[s]) sel = SLOT_W'(s);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        if (st_q.pend) begin
            st_d.pend = 1'b0;
            if (st_q.qual && (|eff)) begin
                st_d.wake = 1'b1;
                st_d.slot = sel;
            end
        end
        if (frame_end) begin
            st_d.pend  = 1'b1;
            st_d.qual  = addr_hit && fcs_ok && pme_en;
            st_d.lmode = long_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake      = st_q.wake;
    assign wake_slot = st_q.slot;

    // R6: a pulse only follows a frame whose qualifiers were all set
    p_wake_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |-> $past(st_q.qual));

    // R9: the pulse sits two edges after the end-of-frame byte
    p_wake_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |-> $past(frame_end, 2));

    // R8: an odd partner of a joined pair is never reported
    p_long_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wake && st_q.lmode && st_q.slot >= SLOT_W'(FIRST_LONG)) |-> !st_q.slot[0]);

endmodule

// File: rtl/wkf_matcher.sv
module wkf_matcher
    import wkf_pkg::*;
#(
    parameter int OFFS_W = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_vld,
    input  logic [7:0]                   rx_dat,
    input  logic [OFFS_W-1:0]            rx_off,
    input  logic                         rx_eof,
    input  logic                         rx_crc_ok,
    input  logic                         rx_addr_hit,
    input  logic                         pme_en,
    input  logic                         long_mode,
    input  logic [SLOT_CNT*NORM_LEN-1:0] slot_mask,
    input  logic [SLOT_CNT*8-1:0]        slot_crc_lo,
    input  logic [SLOT_CNT*8-1:0]        slot_crc_hi,
    output logic                         wake,
    output logic [SLOT_W-1:0]            wake_slot
);

    logic [SLOT_CNT-1:0] norm_hit;
    logic [LONG_CNT-1:0] long_hit;
    logic                frame_end;

    assign frame_end = rx_vld && rx_eof;

    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_norm
        wkf_lane #(
            .OFFS_W  (OFFS_W),
            .WIN_LO  (NORM_LO),
            .WIN_LEN (NORM_LEN),
            .CRC_W   (8),
            .POLY    (POLY_SHORT),
            .USE_LAST(1'b1)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .byte_vld (rx_vld),
            .byte_dat (rx_dat),
            .byte_off (rx_off),
            .lane_mask(slot_mask[s*NORM_LEN +: NORM_LEN]),
            .ref_crc  (slot_crc_lo[s*8 +: 8]),
            .ref_last (slot_crc_hi[s*8 +: 8]),
            .hit      (norm_hit[s])
        );
    end

    // Even slot owns the low half of the joined mask, odd slot the high half
    for (genvar k = 0; k < LONG_CNT; k++) begin : g_long
        localparam int EV = FIRST_LONG + 2 * k;
        wkf_lane #(
            .OFFS_W  (OFFS_W),
            .WIN_LO  (0),
            .WIN_LEN (LONG_LEN),
            .CRC_W   (16),
            .POLY    (POLY_LONG),
            .USE_LAST(1'b0)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .byte_vld (rx_vld),
            .byte_dat (rx_dat),
            .byte_off (rx_off),
            .lane_mask(slot_mask[EV*NORM_LEN +: LONG_LEN]),
            .ref_crc  ({slot_crc_hi[EV*8 +: 8], slot_crc_lo[EV*8 +: 8]}),
            .ref_last (8'h00),
            .hit      (long_hit[k])
        );
    end

    wkf_decide u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_end(frame_end),
        .addr_hit (rx_addr_hit),
        .fcs_ok   (rx_crc_ok),
        .pme_en   (pme_en),
        .long_mode(long_mode),
        .norm_hit (norm_hit),
        .long_hit (long_hit),
        .wake     (wake),
        .wake_slot(wake_slot)
    );

    // R1: no pulse in the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wake);

endmodule

// File: tb/wkf_matcher_tb.sv
`timescale 1ns/1ps
module wkf_matcher_tb_top;

    localparam int NS = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_vld = 1'b0;
    logic [7:0]       rx_dat = '0;
    logic [10:0]      rx_off = '0;
    logic             rx_eof = 1'b0;
    logic             rx_crc_ok = 1'b1;
    logic             rx_addr_hit = 1'b1;
    logic             pme_en = 1'b1;
    logic             long_mode = 1'b0;
    logic [NS*64-1:0] slot_mask;
    logic [NS*8-1:0]  slot_crc_lo;
    logic [NS*8-1:0]  slot_crc_hi;
    logic             wake;
    logic [2:0]       wake_slot;

    logic [63:0] msk [NS];
    logic [7:0]  lo  [NS];
    logic [7:0]  hi  [NS];
    logic [7:0]  frm [128];

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            slot_mask[s*64 +: 64] = msk[s];
            slot_crc_lo[s*8 +: 8] = lo[s];
            slot_crc_hi[s*8 +: 8] = hi[s];
        end
    end

    wkf_matcher dut_i (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_dat(rx_dat),
        .rx_off(rx_off), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
        .rx_addr_hit(rx_addr_hit), .pme_en(pme_en), .long_mode(long_mode),
        .slot_mask(slot_mask), .slot_crc_lo(slot_crc_lo), .slot_crc_hi(slot_crc_hi),
        .wake(wake), .wake_slot(wake_slot)
    );

    function automatic logic [7:0] c8(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c ^ b;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [15:0] c16(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h8005) : (r << 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic make_frame(input int seed);
        for (int i = 0; i < 128; i++) frm[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2));
    endtask

    task automatic clear_all();
        for (int s = 0; s < NS; s++) begin
            msk[s] = '0; lo[s] = '0; hi[s] = '0;
        end
    endtask

    // Normal slot: 8-bit CRC and last selected byte over offsets 12..75
    task automatic prog_norm(input int s);
        logic [7:0] c = 8'hFF;
        logic [7:0] l = 8'h00;
        for (int k = 0; k < 64; k++) begin
            if (msk[s][k]) begin
                c = c8(c, frm[12 + k]);
                l = frm[12 + k];
            end
        end
        lo[s] = c;
        hi[s] = l;
    endtask

    // Long pair e,e+1: 16-bit CRC over offsets 0..127
    task automatic prog_long(input int e);
        logic [127:0] m = {msk[e + 1], msk[e]};
        logic [15:0]  c = 16'hFFFF;
        for (int k = 0; k < 128; k++) if (m[k]) c = c16(c, frm[k]);
        lo[e] = c[7:0];
        hi[e] = c[15:8];
    endtask

    task automatic run_check(input bit ew, input int es, input string req);
        logic w0, w1, w2;
        logic [2:0] s1;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_dat = frm[i]; rx_off = 11'(i); rx_eof = (i == 127);
        end
        @(negedge clk);
        rx_vld = 1'b0; rx_eof = 1'b0;
        w0 = wake;
        @(negedge clk);
        w1 = wake; s1 = wake_slot;
        @(negedge clk);
        w2 = wake;
        check(w0 == 1'b0, {req, " early pulse"}, int'(w0), 0);
        check(w1 == ew, {req, " wake"}, int'(w1), int'(ew));
        if (ew) check(int'(s1) == es, {req, " slot"}, int'(s1), es);
        check(w2 == 1'b0, {req, " pulse width"}, int'(w2), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        clear_all();
        make_frame(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wake == 1'b0, "R1 wake", int'(wake), 0);
        check(wake_slot == 3'd0, "R1 slot", int'(wake_slot), 0);

        // R3 R4 R9: each slot alone, normal mode
        for (int s = 0; s < NS; s++) begin
            clear_all();
            make_frame(s + 1);
            msk[s] = (64'h1 << (s * 7)) | 64'h0F00_3000_0000_8104;
            prog_norm(s);
            run_check(1'b1, s, "R3");
            // R4 wrong CRC, then wrong last byte
            lo[s] = lo[s] ^ 8'h01;
            run_check(1'b0, 0, "R4 crc");
            lo[s] = lo[s] ^ 8'h01;
            hi[s] = hi[s] ^ 8'h80;
            run_check(1'b0, 0, "R4 last");
        end

        // R5: empty mask with references equal to seed and zero
        clear_all();
        make_frame(20);
        lo[4] = 8'hFF; hi[4] = 8'h00;
        run_check(1'b0, 0, "R5");

        // R2: window edges at 12 and 75
        clear_all();
        make_frame(21);
        msk[2] = 64'h8000_0000_0000_0001;
        prog_norm(2);
        frm[11] = ~frm[11]; frm[76] = ~frm[76]; frm[40] = ~frm[40];
        run_check(1'b1, 2, "R2 outside");
        frm[12] = ~frm[12];
        run_check(1'b0, 0, "R2 edge12");
        frm[12] = ~frm[12];
        frm[75] = ~frm[75];
        run_check(1'b0, 0, "R2 edge75");

        // R6: qualifier sweep
        clear_all();
        make_frame(22);
        msk[1] = 64'h00FF_0000_1111_0000;
        prog_norm(1);
        for (int q = 0; q < 8; q++) begin
            rx_addr_hit = q[0]; rx_crc_ok = q[1]; pme_en = q[2];
            run_check(q == 7, 1, "R6");
        end
        rx_addr_hit = 1'b1; rx_crc_ok = 1'b1; pme_en = 1'b1;

        // R9: lowest index wins
        clear_all();
        make_frame(23);
        msk[6] = 64'hF; msk[3] = 64'hF0; msk[5] = 64'h1F00;
        prog_norm(6); prog_norm(3); prog_norm(5);
        run_check(1'b1, 3, "R9 prio");
        msk[0] = 64'h3;
        prog_norm(0);
        run_check(1'b1, 0, "R9 prio0");

        // R7: each long pair, high CRC byte instead of last byte
        long_mode = 1'b1;
        for (int e = 2; e < 8; e += 2) begin
            clear_all();
            make_frame(30 + e);
            msk[e]     = 64'h0000_0000_0000_000F | (64'h1 << (e * 5));
            msk[e + 1] = 64'h8000_0000_0000_007F;
            prog_long(e);
            run_check(1'b1, e, "R7");
            long_mode = 1'b0;
            run_check(1'b0, 0, "R7 off");
            long_mode = 1'b1;
            lo[e] = lo[e] ^ 8'h10;
            run_check(1'b0, 0, "R7 bad crc");
        end

        // R8: odd slot ignored in long mode, slots 0/1 still normal
        clear_all();
        make_frame(40);
        msk[3] = 64'h0000_0F00_0000_00F0;
        prog_norm(3);
        run_check(1'b0, 0, "R8 odd");
        long_mode = 1'b0;
        run_check(1'b1, 3, "R8 odd normal");
        long_mode = 1'b1;
        clear_all();
        make_frame(41);
        msk[0] = 64'h0000_0000_0001_0001;
        prog_norm(0);
        msk[6] = 64'hFF; msk[7] = 64'h1;
        prog_long(6);
        run_check(1'b1, 0, "R8 slot0");
        msk[0] = '0; lo[0] = '0; hi[0] = '0;
        run_check(1'b1, 6, "R8 long6");
        long_mode = 1'b0;

        // R10: a non-matching frame does not carry into the next
        clear_all();
        make_frame(50);
        msk[5] = 64'h0303_0000_0000_0101;
        prog_norm(5);
        make_frame(51);
        run_check(1'b0, 0, "R10 other");
        make_frame(50);
        run_check(1'b1, 5, "R10 again");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule